// File: doc/BRIEF.md
# Multi-mode 16-bit peripheral timer

This block is a register-mapped 16-bit timer for a small processor subsystem. Software reaches it over a single-cycle word bus. The bus gives access to a control register, the counter itself, three compare channels (each with a channel-control word and a compare word) and a read-only interrupt vector word. The counter advances on ticks from a prescaler that divides the system clock by 1, 2, 4 or 8. It has three counting modes, plus a halted state. In the up mode it runs from zero to the compare-0 value and back to zero. In the continuous mode it runs through the full 16-bit range. In the up-down mode it climbs to the compare-0 value and then descends to zero.

The block raises two interrupt lines. The compare-0 line has its own vector, and the interrupt controller gives it the higher priority. The overflow line is shared with the vector word. Reading the vector word returns a code for a pending overflow and clears it. A compare-0 flag is cleared when the interrupt controller acknowledges it. Compare channels 1 and 2 are plain storage; only channel 0 takes part in matching.

Register word indexes: 0 control, 1 counter, 2..4 channel control 0..2, 5..7 compare 0..2, 8 vector.

Top module: `ptimer16`

## Requirements
- R1: Registers read back what was written, with reserved bits reading 0. The control word keeps bits 7:6, 5:4, 1 and 0, so its read mask is 0x00F3. The counter and compare words keep all 16 bits. Each channel-control word keeps bit 4 (interrupt enable) and bit 0 (flag), so its read mask is 0x0011. After reset every register reads 0.
- R2: Control bits 7:6 pick the tick rate: 00 gives every cycle, 01 every 2nd cycle, 10 every 4th and 11 every 8th. After a start that clears the counter, the counter holds floor(k/N) k cycles later.
- R3: Mode field 00 (control bits 5:4) halts the counter, and the counter value then stays put.
- R4: Mode 01 (up) counts 0,1,…,C0 and then returns to 0, where C0 is compare 0. The return to 0 sets the overflow flag.
- R5: Mode 10 (continuous) counts upward from any preloaded value. It wraps from 0xFFFF to 0x0000 and sets the overflow flag on the wrap.
- R6: Mode 11 (up-down) counts up to C0 and then down to 0, and repeats. Reaching 0 while descending sets the overflow flag.
- R7: The compare-0 flag (channel-control 0, bit 0) is set on the tick at which the counter becomes equal to C0. A pulse on cmp0_ack clears it. irq_cmp0 is high exactly when that flag and channel-control 0 bit 4 are both 1.
- R8: The overflow flag is control bit 0, and control bit 1 is its enable. A write stores bit 0, so writing 0 clears the flag. irq_ovf is high exactly when the flag and the enable are both 1.
- R9: The vector word reads 0x000A while an enabled overflow is pending and 0 otherwise. A read that returns 0x000A clears the overflow flag. Writes to the vector word change nothing.
- R10: Writing control with bit 2 set zeroes the counter, the prescaler phase and the up-down direction in that cycle. Bit 2 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| cmp0_ack | input | 1 | Compare-0 interrupt acknowledge pulse |
| irq_cmp0 | output | 1 | Compare-0 interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
Every cycle, the embedded assertions check several things. A halted counter does not move. An up-mode count stays at or below compare 0. A continuous count wraps to zero, and a down-count from one sets the overflow flag. Back-to-back ticks occur only at divide-by-one. Event pulses land in their flags, a vector read clears the flag, and a clear write zeroes the counter. Only the bench scenarios show whole sequences: exact tick spacing for each divider, the up-down turn points, readback masks with 0xAAAA/0x5555/0x0000, acknowledge clearing, and that writes to the vector word have no effect.

// File: rtl/ptimer16_pkg.sv
package ptimer16_pkg;

    localparam int DW = 16;
    localparam int AW = 4;

    localparam int A_CTRL  = 0;
    localparam int A_CNT   = 1;
    localparam int A_CCTL0 = 2;

    localparam int CTRL_CLR_BIT = 2;
    localparam int CH_IE_BIT    = 4;
    localparam int CH_FLAG_BIT  = 0;

    localparam logic [DW-1:0] VEC_OVF = 16'h000A;

    typedef enum logic [1:0] {
        MODE_HALT = 2'b00,
        MODE_UP   = 2'b01,
        MODE_CONT = 2'b10,
        MODE_UPDN = 2'b11
    } mode_e;

    typedef struct packed {
        logic [1:0] div;
        mode_e      mode;
        logic       ovf_ie;
        logic       ovf_flag;
    } ctrl_t;

    typedef struct packed {
        logic ie;
        logic flag;
    } chan_t;

    typedef struct packed {
        logic ovf;
        logic cmp;
    } evt_t;

    function automatic logic [DW-1:0] ctrl_pack(ctrl_t c);
        return {8'h00, c.div, c.mode, 2'b00, c.ovf_ie, c.ovf_flag};
    endfunction

    function automatic logic [DW-1:0] chan_pack(chan_t c);
        logic [DW-1:0] w;
        w = '0;
        w[CH_IE_BIT]   = c.ie;
        w[CH_FLAG_BIT] = c.flag;
        return w;
    endfunction

endpackage

// File: rtl/ptimer16_presc.sv
module ptimer16_presc #(
    parameter int PS_W = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       clr,
    input  logic [1:0] div,
    output logic       tick
);
    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] lim;

    assign lim  = {PS_W{1'b1}} >> (PS_W - int'(div));
    assign tick = run && (ps_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ps_q <= '0;
        end else if (run) begin
            ps_q <= tick ? '0 : ps_q + 1'b1;
        end
    end

    // consecutive ticks only happen when the divider is one
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && $past(tick) && !$past(rst) && !$past(clr) && $stable(div)) |-> (lim == '0)); // R2

endmodule

// File: rtl/ptimer16_count.sv
module ptimer16_count import ptimer16_pkg::*; (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  mode_e         mode,
    input  logic [DW-1:0] cmp0,
    input  logic          clr,
    input  logic          ld,
    input  logic [DW-1:0] ld_val,
    output logic [DW-1:0] cnt,
    output evt_t          evt
);
    logic [DW-1:0] cnt_q, nxt;
    logic          dir_q, ndir;   // 0 = rising, 1 = falling
    logic          ovf_c, adv;

    assign adv = tick && !clr && !ld;

    always_comb begin
        nxt   = cnt_q;
        ndir  = dir_q;
        ovf_c = 1'b0;
        case (mode)
            MODE_UP: begin
                if (cnt_q >= cmp0) begin
                    nxt   = '0;
                    ovf_c = 1'b1;
                end else begin
                    nxt = cnt_q + 1'b1;
                end
            end
            MODE_CONT: begin
                nxt   = cnt_q + 1'b1;
                ovf_c = (cnt_q == '1);
            end
            MODE_UPDN: begin
                if (!dir_q && cnt_q < cmp0) begin
                    nxt = cnt_q + 1'b1;
                end else if (!dir_q && cnt_q == '0) begin
                    nxt = '0;
                end else if (cnt_q <= 1) begin
                    nxt   = '0;
                    ndir  = 1'b0;
                    ovf_c = 1'b1;
                end else begin
                    nxt  = cnt_q - 1'b1;
                    ndir = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign evt.ovf = adv && ovf_c;
    assign evt.cmp = adv && (nxt == cmp0);
    assign cnt     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else if (ld) begin
            cnt_q <= ld_val;
        end else if (adv) begin
            cnt_q <= nxt;
            dir_q <= ndir;
        end
    end

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HALT && !clr && !ld) |=> $stable(cnt_q)); // R3
    AST_UP_CEILING: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_UP && !clr && !ld && cnt_q <= cmp0) |=> (cnt_q <= $past(cmp0))); // R4
    AST_CONT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && mode == MODE_CONT && cnt_q == '1) |=> (cnt_q == '0)); // R5
    AST_DOWN_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (adv && mode == MODE_UPDN && dir_q && cnt_q == 1) |-> evt.ovf); // R6

endmodule

// File: rtl/ptimer16.sv
module ptimer16 import ptimer16_pkg::*; #(
    parameter int NCH  = 3,
    parameter int PS_W = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          cmp0_ack,
    output logic          irq_cmp0,
    output logic          irq_ovf
);
    localparam int A_CCMP0 = A_CCTL0 + NCH;
    localparam int A_VEC   = A_CCMP0 + NCH;

    ctrl_t         ctrl_q;
    chan_t         chan_q [NCH];
    logic [DW-1:0] cmp_q  [NCH];
    logic [DW-1:0] cnt;
    evt_t          evt;
    logic          tick;

    logic wr_en, rd_en, ctrl_wr, clr, cnt_ld, ovf_pend, vec_clr;

    assign wr_en    = bus_sel && bus_wr;
    assign rd_en    = bus_sel && !bus_wr;
    assign ctrl_wr  = wr_en && int'(bus_addr) == A_CTRL;
    assign clr      = ctrl_wr && bus_wdata[CTRL_CLR_BIT];
    assign cnt_ld   = wr_en && int'(bus_addr) == A_CNT;
    assign ovf_pend = ctrl_q.ovf_flag && ctrl_q.ovf_ie;
    assign vec_clr  = rd_en && int'(bus_addr) == A_VEC && ovf_pend;

    ptimer16_presc #(.PS_W(PS_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.mode != MODE_HALT),
        .clr  (clr),
        .div  (ctrl_q.div),
        .tick (tick)
    );

    ptimer16_count u_count (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .mode   (ctrl_q.mode),
        .cmp0   (cmp_q[0]),
        .clr    (clr),
        .ld     (cnt_ld),
        .ld_val (bus_wdata),
        .cnt    (cnt),
        .evt    (evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.div      <= bus_wdata[7:6];
                ctrl_q.mode     <= mode_e'(bus_wdata[5:4]);
                ctrl_q.ovf_ie   <= bus_wdata[1];
                ctrl_q.ovf_flag <= bus_wdata[0];
            end
            if (vec_clr) ctrl_q.ovf_flag <= 1'b0;
            if (evt.ovf) ctrl_q.ovf_flag <= 1'b1;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        chan_t         ch_r;
        logic [DW-1:0] cmp_r;
        logic          sel_ctl, sel_cmp;

        assign sel_ctl = wr_en && int'(bus_addr) == A_CCTL0 + g;
        assign sel_cmp = wr_en && int'(bus_addr) == A_CCMP0 + g;

        always_ff @(posedge clk) begin
            if (rst) begin
                ch_r  <= '0;
                cmp_r <= '0;
            end else begin
                if (sel_ctl) begin
                    ch_r.ie   <= bus_wdata[CH_IE_BIT];
                    ch_r.flag <= bus_wdata[CH_FLAG_BIT];
                end
                if (sel_cmp) cmp_r <= bus_wdata;
                if (g == 0) begin
                    if (cmp0_ack) ch_r.flag <= 1'b0;
                    if (evt.cmp)  ch_r.flag <= 1'b1;
                end
            end
        end

        assign chan_q[g] = ch_r;
        assign cmp_q[g]  = cmp_r;
    end

    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) == A_CTRL) bus_rdata = ctrl_pack(ctrl_q);
        if (int'(bus_addr) == A_CNT)  bus_rdata = cnt;
        if (int'(bus_addr) == A_VEC)  bus_rdata = ovf_pend ? VEC_OVF : '0;
        for (int i = 0; i < NCH; i++) begin
            if (int'(bus_addr) == A_CCTL0 + i) bus_rdata = chan_pack(chan_q[i]);
            if (int'(bus_addr) == A_CCMP0 + i) bus_rdata = cmp_q[i];
        end
    end

    assign irq_cmp0 = chan_q[0].flag && chan_q[0].ie;
    assign irq_ovf  = ovf_pend;

    AST_OVF_LATCHES: assert property (@(posedge clk) disable iff (rst)
        evt.ovf |=> ctrl_q.ovf_flag); // R8
    AST_CMP_LATCHES: assert property (@(posedge clk) disable iff (rst)
        evt.cmp |=> chan_q[0].flag); // R7
    AST_VEC_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (vec_clr && !evt.ovf) |=> !ctrl_q.ovf_flag); // R9
    AST_VEC_CODES: assert property (@(posedge clk) disable iff (rst)
        (rd_en && int'(bus_addr) == A_VEC) |-> (bus_rdata == '0 || bus_rdata == VEC_OVF)); // R9
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)); // R10

endmodule

// File: tb/sim_ptimer16.sv
`timescale 1ns/1ps
module sim_ptimer16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cmp0_ack = 1'b0;
    logic        irq_cmp0, irq_ovf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    ptimer16 u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp0_ack(cmp0_ack), .irq_cmp0(irq_cmp0), .irq_ovf(irq_ovf)
    );

    // behavioural reference state
    int m_div = 0, m_mode = 0, m_oie = 0, m_of = 0;
    int m_cnt = 0, m_ps = 0, m_dir = 0;
    int m_ie [3] = '{0, 0, 0};
    int m_f  [3] = '{0, 0, 0};
    int m_cmp[3] = '{0, 0, 0};

    function automatic int m_read(int a);
        if (a == 0) return (m_div << 6) | (m_mode << 4) | (m_oie << 1) | m_of;
        if (a == 1) return m_cnt;
        if (a >= 2 && a <= 4) return (m_ie[a-2] << 4) | m_f[a-2];
        if (a >= 5 && a <= 7) return m_cmp[a-5];
        if (a == 8) return (m_of && m_oie) ? 'h000A : 0;
        return 0;
    endfunction

    always @(posedge clk) begin
        int lim, nx, nd, a, wd;
        bit tk, adv, wr, rd, clr, ld, eo, ec, vrd;
        if (rst) begin
            m_div = 0; m_mode = 0; m_oie = 0; m_of = 0;
            m_cnt = 0; m_ps = 0; m_dir = 0;
            for (int i = 0; i < 3; i++) begin m_ie[i] = 0; m_f[i] = 0; m_cmp[i] = 0; end
        end else begin
            wr  = bus_sel && bus_wr;
            rd  = bus_sel && !bus_wr;
            a   = int'(bus_addr);
            wd  = int'(bus_wdata);
            lim = (1 << m_div) - 1;
            tk  = (m_mode != 0) && (m_ps >= lim);
            clr = wr && a == 0 && wd[2];
            ld  = wr && a == 1;
            nx = m_cnt; nd = m_dir; eo = 0;
            if (m_mode == 1) begin
                if (m_cnt >= m_cmp[0]) begin nx = 0; eo = 1; end else nx = m_cnt + 1;
            end else if (m_mode == 2) begin
                nx = (m_cnt + 1) & 'hFFFF; eo = (m_cnt == 'hFFFF);
            end else if (m_mode == 3) begin
                if (m_dir == 0 && m_cnt < m_cmp[0]) nx = m_cnt + 1;
                else if (m_dir == 0 && m_cnt == 0) nx = 0;
                else if (m_cnt <= 1) begin nx = 0; nd = 0; eo = 1; end
                else begin nx = m_cnt - 1; nd = 1; end
            end
            adv = tk && !clr && !ld;
            ec  = adv && (nx == m_cmp[0]);
            eo  = adv && eo;
            vrd = rd && a == 8 && m_of && m_oie;
            if (clr) m_ps = 0;
            else if (m_mode != 0) m_ps = tk ? 0 : m_ps + 1;
            if (clr) begin m_cnt = 0; m_dir = 0; end
            else if (ld) m_cnt = wd & 'hFFFF;
            else if (adv) begin m_cnt = nx; m_dir = nd; end
            if (wr && a == 0) begin
                m_div = (wd >> 6) & 3; m_mode = (wd >> 4) & 3;
                m_oie = (wd >> 1) & 1; m_of = wd & 1;
            end
            if (vrd) m_of = 0;
            if (eo) m_of = 1;
            for (int i = 0; i < 3; i++) begin
                if (wr && a == 2 + i) begin m_ie[i] = (wd >> 4) & 1; m_f[i] = wd & 1; end
                if (wr && a == 5 + i) m_cmp[i] = wd & 'hFFFF;
            end
            if (cmp0_ack) m_f[0] = 0;
            if (ec) m_f[0] = 1;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        int exp_rd;
        if (!rst && !done) begin
            #2;
            exp_rd = m_read(int'(bus_addr));
            checks++;
            if (int'(bus_rdata) != exp_rd ||
                irq_cmp0 != (m_f[0] != 0 && m_ie[0] != 0) ||
                irq_ovf  != (m_of != 0 && m_oie != 0)) begin
                fails++;
                $display("FAIL %s model: rdata=%h/%h irq_cmp0=%0b/%0b irq_ovf=%0b/%0b (actual/expected)",
                         cur_req, bus_rdata, exp_rd[15:0], irq_cmp0, (m_f[0] != 0 && m_ie[0] != 0),
                         irq_ovf, (m_of != 0 && m_oie != 0));
            end
        end
    end

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic bus_w(int a, int d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 16'(d);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rchk(string tag, int a, int exp);
        int v;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'(a);
        #1 v = int'(bus_rdata);
        chk(tag, v, exp);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int pats[3] = '{'hAAAA, 'h5555, 'h0000};
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        cur_req = "R1";
        rchk("R1 ctrl reset", 0, 0);
        rchk("R1 cnt reset", 1, 0);
        rchk("R9 vec reset", 8, 0);
        chk("R7 irq_cmp0 reset", int'(irq_cmp0), 0);
        chk("R8 irq_ovf reset", int'(irq_ovf), 0);

        // R1 readback patterns
        foreach (pats[p]) begin bus_w(1, pats[p]); rchk("R1 cnt rw", 1, pats[p]); end
        for (int i = 0; i < 3; i++)
            foreach (pats[p]) begin bus_w(2 + i, pats[p]); rchk("R1 chctl rw", 2 + i, pats[p] & 'h11); end
        for (int i = 0; i < 3; i++)
            foreach (pats[p]) begin bus_w(5 + i, pats[p]); rchk("R1 cmp rw", 5 + i, pats[p]); end
        bus_w(5, 'hFFFF);
        foreach (pats[p]) begin bus_w(0, pats[p]); rchk("R1 ctrl rw", 0, pats[p] & 'hF3); end
        cur_req = "R9";
        bus_w(8, 'hAAAA);
        rchk("R9 vec write ignored", 8, 0);

        // R10 clear
        cur_req = "R10";
        bus_w(1, 'h1234);
        bus_w(0, 'h0004);
        rchk("R10 clear cnt", 1, 0);
        rchk("R10 bit2 reads 0", 0, 0);
        bus_w(0, 'h0020);
        idle(5);
        bus_w(0, 'h0024);
        rchk("R10 clear while running", 1, 0);
        rchk("R10 ctrl after clear", 0, 'h0020);

        // R3 halt
        cur_req = "R3";
        bus_w(0, 0);
        bus_w(1, 'h55);
        idle(10);
        rchk("R3 halted cnt", 1, 'h55);

        // R2 prescaler
        cur_req = "R2";
        for (int d = 0; d < 4; d++) begin
            bus_w(0, (d << 6) | 'h24);
            idle(16);
            rchk("R2 divided count", 1, 16 >> d);
            bus_w(0, 0);
        end

        // R4 up mode
        cur_req = "R4";
        bus_w(5, 5);
        bus_w(0, 'h0014);
        idle(5);
        rchk("R4 top value", 1, 5);
        rchk("R7 flag at match", 2, 'h0001);
        rchk("R4 ovf on return", 0, 'h0011);
        rchk("R4 restart", 1, 2);
        bus_w(0, 0);
        bus_w(2, 0);

        // R5 continuous, R8 flag/enable, R9 vector
        cur_req = "R5";
        bus_w(1, 'hFFF0);
        bus_w(0, 'h0022);
        idle(15);
        rchk("R5 at max", 1, 'hFFFF);
        rchk("R5 wrapped", 1, 0);
        rchk("R5 ovf flag", 0, 'h0023);
        chk("R8 irq_ovf high", int'(irq_ovf), 1);
        cur_req = "R9";
        rchk("R9 vector code", 8, 'h000A);
        rchk("R9 read cleared flag", 0, 'h0022);
        chk("R8 irq_ovf low", int'(irq_ovf), 0);
        rchk("R9 nothing pending", 8, 0);
        cur_req = "R8";
        bus_w(0, 'h0023);
        rchk("R8 flag written 1", 0, 'h0023);
        bus_w(0, 'h0022);
        rchk("R8 flag written 0", 0, 'h0022);
        bus_w(0, 0);

        // R6 up-down
        cur_req = "R6";
        bus_w(5, 3);
        bus_w(0, 'h0034);
        idle(3);
        rchk("R6 peak", 1, 3);
        rchk("R6 down 2", 1, 2);
        rchk("R6 down 1", 1, 1);
        rchk("R6 floor", 1, 0);
        rchk("R6 ovf at floor", 0, 'h0031);
        rchk("R7 flag updn", 2, 'h0001);
        chk("R7 irq gated by enable", int'(irq_cmp0), 0);
        rchk("R6 rising again", 1, 3);
        rchk("R6 falling again", 1, 2);
        bus_w(0, 0);

        // R7 acknowledge
        cur_req = "R7";
        bus_w(2, 'h0010);
        bus_w(5, 2);
        bus_w(0, 'h0014);
        idle(1);
        bus_w(0, 0);
        chk("R7 irq_cmp0 raised", int'(irq_cmp0), 1);
        rchk("R7 cnt at match", 1, 2);
        cmp0_ack = 1'b1;
        @(negedge clk);
        cmp0_ack = 1'b0;
        #1 chk("R7 irq_cmp0 after ack", int'(irq_cmp0), 0);
        rchk("R7 flag after ack", 2, 'h0010);

        idle(2);
        finish_run();
    end

endmodule